// File: doc/BRIEF.md
# Palette DAC Register File with Extended Index Window

This block is the processor-facing register interface of a palette DAC. It has four byte-wide ports. Two of them set the palette write pointer and the palette read pointer. One carries the palette data, and one holds a command byte. In the normal mode a colour entry is written or read as three byte transfers, red first, then green, then blue. The entry pointer steps forward by itself after the blue byte. The palette is a 256-entry store of three colour bytes. It has a second, registered lookup port for the pixel path.

Command bit 4 changes what the ports mean. While it is set, the read-pointer port loads an index into a hidden bank of configuration registers. The write-pointer port becomes the read/write data window of that bank. A read of the data port returns the index. The bank holds a DAC width select (6 or 8 bits), four fixed identification bytes, a 24-bit pixel mask and a 32-bit packing enable. All of them drive configuration outputs toward the pixel logic.

Top module: `pdac_regfile`

## Requirements
- R1: After reset the command byte is 00h, both palette pointers and both byte counters are zero, the bank index is 00h, the DAC width is 6 bits, packing is off and the pixel mask is FFFFFFh.
- R2: Port 3 reads back the last byte written to it in either mode, and `cfg_cmd` drives that byte. Bit 4 of it selects the extended window.
- R3: In normal mode a write to port 0 loads the write pointer and restarts the byte counter. Three writes to port 1 store R, G and B into that entry on the third write, and the pointer then advances by one. A read of port 0 returns the write pointer.
- R4: In normal mode a write to port 2 loads the read pointer and restarts its counter. Reads of port 1 return R, G, B of that entry in turn, and the pointer then advances by one.
- R5: With the DAC width at 6 bits, palette bytes returned on port 1 and on `pix_rgb` have bits 7:6 cleared. At 8 bits the full stored byte is returned.
- R6: In extended mode a write to port 2 loads the bank index, and a read of port 1 returns it. A write to port 1 changes neither the palette nor the write byte counter.
- R7: In extended mode, reads and writes on port 0 access the bank register at the current index and leave the palette write pointer unchanged.
- R8: Bank register 08h bit 0 selects the 8-bit DAC width (1) or the 6-bit width (0). It reads back with bits 7:1 zero and drives `cfg_dac8`.
- R9: Bank registers 09h, 0Ah, 0Bh and 0Ch always read 53h, 3Ah, B1h and 41h. Writes to them are ignored.
- R10: Bank registers 0Dh, 0Eh and 0Fh are bits 7:0, 15:8 and 23:16 of `cfg_mask`. Each reads back its byte.
- R11: Bank register 10h bit 0 drives `cfg_pack32` and reads back with bits 7:1 zero.
- R12: Bank indices that are not implemented read 00h and ignore writes.
- R13: `pix_rgb` shows entry `pix_index` as {R,G,B}, with R in bits 23:16, one clock after the index is presented. If the blue write that commits that entry falls in the same cycle, the old colour is shown for one clock and the new one after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Access strobe for the selected port |
| we | input | 1 | Write when high with cs |
| re | input | 1 | Read when high with cs; reads of port 1 advance the read counter |
| port | input | 2 | 0 write pointer / bank data, 1 palette data / bank index readback, 2 read pointer / bank index load, 3 command |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid combinationally while cs and re are high, else zero |
| pix_index | input | 8 | Palette entry requested by the pixel path |
| pix_rgb | output | 24 | Registered colour of the requested entry, width-adjusted |
| cfg_cmd | output | 8 | Command byte |
| cfg_dac8 | output | 1 | 8-bit DAC width selected |
| cfg_mask | output | 24 | Pixel mask |
| cfg_pack32 | output | 1 | Fourth discarded byte enabled |

## Verification
The processor write that commits a palette entry can land in the same clock as the pixel port's lookup of that entry. The bench holds `pix_index` on an entry that already has a known colour, then rewrites the entry so that its blue byte arrives with the index held. It expects the old colour in the first sample after that edge and the new colour one clock later. A second overlap comes from the extended window: writes to port 1 while the window is open must leave the write counter where it was. This is judged by a fresh three-byte write after the window closes, whose bytes must read back unshifted.

// File: rtl/pdac_pkg.sv
package pdac_pkg;

  localparam int DW = 8;

  typedef enum logic [1:0] {
    PORT_WPTR = 2'd0,
    PORT_DATA = 2'd1,
    PORT_RPTR = 2'd2,
    PORT_CMD  = 2'd3
  } port_e;

  localparam logic [7:0] XR_WIDTH = 8'h08;
  localparam logic [7:0] XR_ID_LO = 8'h09;
  localparam logic [7:0] XR_ID_HI = 8'h0C;
  localparam logic [7:0] XR_MSK_LO = 8'h0D;
  localparam logic [7:0] XR_MSK_HI = 8'h0F;
  localparam logic [7:0] XR_PACK  = 8'h10;

  localparam int CMD_XWIN_BIT = 4;

  // identification constant for index 09h..0Ch
  function automatic logic [7:0] id_byte(input logic [1:0] k);
    case (k)
      2'd0:    id_byte = 8'h53;
      2'd1:    id_byte = 8'h3A;
      2'd2:    id_byte = 8'hB1;
      default: id_byte = 8'h41;
    endcase
  endfunction

  // colour byte as seen at the chosen DAC width
  function automatic logic [7:0] width_fit(input logic [7:0] b, input logic wide);
    width_fit = wide ? b : {2'b00, b[5:0]};
  endfunction

  // three-step byte counter: R -> G -> B -> R
  function automatic logic [1:0] step3(input logic [1:0] s);
    step3 = (s == 2'd2) ? 2'd0 : s + 2'd1;
  endfunction

endpackage

// File: rtl/pdac_palette_ram.sv
module pdac_palette_ram #(
  parameter int ENTRIES = 256,
  parameter int CW      = 8,
  localparam int AW     = $clog2(ENTRIES),
  localparam int LANES  = 3
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [LANES*CW-1:0]   wr_rgb,
  input  logic [AW-1:0]         rd_addr,
  output logic [LANES*CW-1:0]   rd_rgb,
  input  logic [AW-1:0]         pix_addr,
  output logic [LANES*CW-1:0]   pix_raw
);

  // one storage lane per colour component; lane 2 is red (top bits)
  for (genvar c = 0; c < LANES; c++) begin : g_lane
    logic [CW-1:0] lane_mem [ENTRIES];
    logic [CW-1:0] pix_q;

    always_ff @(posedge clk) begin
      if (wr_en) lane_mem[wr_addr] <= wr_rgb[c*CW +: CW];
      pix_q <= lane_mem[pix_addr];
    end

    assign rd_rgb[c*CW +: CW]  = lane_mem[rd_addr];
    assign pix_raw[c*CW +: CW] = pix_q;
  end

endmodule

// File: rtl/pdac_seq.sv
module pdac_seq
  import pdac_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wptr_load,
  input  logic            rptr_load,
  input  logic [AW-1:0]   ptr_val,
  input  logic            data_wr,
  input  logic            data_rd,
  input  logic [DW-1:0]   wdata,
  output logic [AW-1:0]   wptr,
  output logic [AW-1:0]   rptr,
  output logic [1:0]      rsub,
  output logic            commit,
  output logic [3*DW-1:0] commit_rgb
);

  logic [1:0]    wsub;
  logic [DW-1:0] red_hold, grn_hold;
  logic          rd_wrap;

  assign commit     = data_wr && (wsub == 2'd2);
  assign commit_rgb = {red_hold, grn_hold, wdata};
  assign rd_wrap    = data_rd && (rsub == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      wsub     <= 2'd0;
      red_hold <= '0;
      grn_hold <= '0;
    end else if (wptr_load) begin
      wptr <= ptr_val;
      wsub <= 2'd0;
    end else if (data_wr) begin
      if (wsub == 2'd0) red_hold <= wdata;
      if (wsub == 2'd1) grn_hold <= wdata;
      if (commit) wptr <= wptr + 1'b1;
      wsub <= step3(wsub);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      rsub <= 2'd0;
    end else if (rptr_load) begin
      rptr <= ptr_val;
      rsub <= 2'd0;
    end else if (data_rd) begin
      if (rd_wrap) rptr <= rptr + 1'b1;
      rsub <= step3(rsub);
    end
  end

  // R3: the byte counters never reach the unused code 3
  p_counter_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wsub != 2'd3) && (rsub != 2'd3));

  // R3: a committing write moves the write pointer on by one
  p_commit_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !wptr_load |=> wptr == $past(wptr) + 1'b1);

  // R4: the third read moves the read pointer on and restarts at red
  p_read_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wrap && !rptr_load |=> (rptr == $past(rptr) + 1'b1) && (rsub == 2'd0));

endmodule

// File: rtl/pdac_ext_bank.sv
module pdac_ext_bank
  import pdac_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_load,
  input  logic [DW-1:0] idx_val,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] xidx,
  output logic [DW-1:0] reg_rdata,
  output logic          dac8,
  output logic [23:0]   mask,
  output logic          pack32
);

  logic hit_width, hit_id, hit_mask, hit_pack;
  logic [1:0] mask_lane;

  assign hit_width = (xidx == XR_WIDTH);
  assign hit_id    = (xidx >= XR_ID_LO) && (xidx <= XR_ID_HI);
  assign hit_mask  = (xidx >= XR_MSK_LO) && (xidx <= XR_MSK_HI);
  assign hit_pack  = (xidx == XR_PACK);
  assign mask_lane = 2'(xidx - XR_MSK_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xidx <= '0;
    else if (idx_load) xidx <= idx_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac8   <= 1'b0;
      pack32 <= 1'b0;
    end else if (reg_wr) begin
      if (hit_width) dac8   <= reg_wdata[0];
      if (hit_pack)  pack32 <= reg_wdata[0];
    end
  end

  // little-endian mask: lane 0 is bits 7:0
  for (genvar b = 0; b < 3; b++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask[b*8 +: 8] <= 8'hFF;
      else if (reg_wr && hit_mask && (mask_lane == 2'(b))) mask[b*8 +: 8] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_width)     reg_rdata = {7'd0, dac8};
    else if (hit_id)   reg_rdata = id_byte(2'(xidx - XR_ID_LO));
    else if (hit_mask) reg_rdata = mask[mask_lane*8 +: 8];
    else if (hit_pack) reg_rdata = {7'd0, pack32};
  end

  // R6: an index load is visible on the next clock
  p_index_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> xidx == $past(idx_val));

  // R10: the mask moves only on a bank write aimed at a mask byte
  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && hit_mask) |=> $stable(mask));

  // R8 R11: width and packing flags change only on their own index
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && (hit_width || hit_pack)) |=> $stable(dac8) && $stable(pack32));

endmodule

// File: rtl/pdac_regfile.sv
module pdac_regfile
  import pdac_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          we,
  input  logic          re,
  input  logic [1:0]    port,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [AW-1:0] pix_index,
  output logic [23:0]   pix_rgb,
  output logic [7:0]    cfg_cmd,
  output logic          cfg_dac8,
  output logic [23:0]   cfg_mask,
  output logic          cfg_pack32
);

  logic xwin;
  logic do_wr, do_rd;
  logic wptr_load, rptr_load, data_wr, data_rd;
  logic idx_load, xreg_wr;
  logic [AW-1:0] wptr, rptr;
  logic [1:0]    rsub;
  logic          commit;
  logic [23:0]   commit_rgb, rd_rgb, pix_raw;
  logic [7:0]    xidx, xreg_rdata, pal_byte;

  assign xwin  = cfg_cmd[CMD_XWIN_BIT];
  assign do_wr = cs && we;
  assign do_rd = cs && re && !we;

  // port decode, split by window mode
  assign wptr_load = do_wr && !xwin && (port == PORT_WPTR);
  assign rptr_load = do_wr && !xwin && (port == PORT_RPTR);
  assign data_wr   = do_wr && !xwin && (port == PORT_DATA);
  assign data_rd   = do_rd && !xwin && (port == PORT_DATA);
  assign idx_load  = do_wr &&  xwin && (port == PORT_RPTR);
  assign xreg_wr   = do_wr &&  xwin && (port == PORT_WPTR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_cmd <= 8'h00;
    else if (do_wr && (port == PORT_CMD)) cfg_cmd <= wdata;
  end

  pdac_seq #(.ENTRIES(ENTRIES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wptr_load  (wptr_load),
    .rptr_load  (rptr_load),
    .ptr_val    (wdata[AW-1:0]),
    .data_wr    (data_wr),
    .data_rd    (data_rd),
    .wdata      (wdata),
    .wptr       (wptr),
    .rptr       (rptr),
    .rsub       (rsub),
    .commit     (commit),
    .commit_rgb (commit_rgb)
  );

  pdac_palette_ram #(.ENTRIES(ENTRIES), .CW(DW)) u_ram (
    .clk      (clk),
    .wr_en    (commit),
    .wr_addr  (wptr),
    .wr_rgb   (commit_rgb),
    .rd_addr  (rptr),
    .rd_rgb   (rd_rgb),
    .pix_addr (pix_index),
    .pix_raw  (pix_raw)
  );

  pdac_ext_bank u_xbank (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_load  (idx_load),
    .idx_val   (wdata),
    .reg_wr    (xreg_wr),
    .reg_wdata (wdata),
    .xidx      (xidx),
    .reg_rdata (xreg_rdata),
    .dac8      (cfg_dac8),
    .mask      (cfg_mask),
    .pack32    (cfg_pack32)
  );

  // red is served first, from the top byte
  always_comb begin
    case (rsub)
      2'd0:    pal_byte = rd_rgb[23:16];
      2'd1:    pal_byte = rd_rgb[15:8];
      default: pal_byte = rd_rgb[7:0];
    endcase
  end

  always_comb begin
    rdata = 8'h00;
    if (do_rd) begin
      case (port)
        PORT_WPTR: rdata = xwin ? xreg_rdata : 8'(wptr);
        PORT_DATA: rdata = xwin ? xidx : width_fit(pal_byte, cfg_dac8);
        PORT_CMD:  rdata = cfg_cmd;
        default:   rdata = 8'h00;
      endcase
    end
  end

  for (genvar c = 0; c < 3; c++) begin : g_pix
    assign pix_rgb[c*8 +: 8] = width_fit(pix_raw[c*8 +: 8], cfg_dac8);
  end

  // R6: the palette is never written while the window is open
  p_no_commit_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !xwin);

  // R7: bank data writes leave the palette write pointer alone
  p_wptr_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xreg_wr |=> $stable(wptr));

  // R5: narrow width never shows the top two bits of a colour byte
  p_narrow_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !cfg_dac8 |-> rdata[7:6] == 2'b00);

  // R2: command byte follows a port 3 write on the next clock
  p_cmd_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_wr && (port == PORT_CMD) |=> cfg_cmd == $past(wdata));

endmodule

// File: tb/pdac_regfile_test.sv
module pdac_regfile_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, we = 1'b0, re = 1'b0;
  logic [1:0] port = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pix_index = 8'h00;
  logic [23:0] pix_rgb;
  logic [7:0] cfg_cmd;
  logic cfg_dac8, cfg_pack32;
  logic [23:0] cfg_mask;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pdac_regfile uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .re(re), .port(port),
    .wdata(wdata), .rdata(rdata), .pix_index(pix_index), .pix_rgb(pix_rgb),
    .cfg_cmd(cfg_cmd), .cfg_dac8(cfg_dac8), .cfg_mask(cfg_mask),
    .cfg_pack32(cfg_pack32)
  );

  // vector: op(2) port(2) data(8) expect(8) req(4); op 0 write, 1 read-check
  localparam int NV = 59;
  localparam logic [23:0] VEC [NV] = '{
    {2'd0,2'd3,8'h00,8'h00,4'd0},
    {2'd0,2'd0,8'h05,8'h00,4'd0},  // R3 entry 5
    {2'd0,2'd1,8'h11,8'h00,4'd0},
    {2'd0,2'd1,8'h22,8'h00,4'd0},
    {2'd0,2'd1,8'h33,8'h00,4'd0},
    {2'd0,2'd1,8'h0A,8'h00,4'd0},  // entry 6
    {2'd0,2'd1,8'h3B,8'h00,4'd0},
    {2'd0,2'd1,8'hFC,8'h00,4'd0},
    {2'd1,2'd0,8'h00,8'h07,4'd3},  // R3 pointer advanced twice
    {2'd0,2'd2,8'h05,8'h00,4'd0},
    {2'd1,2'd1,8'h00,8'h11,4'd4},  // R4
    {2'd1,2'd1,8'h00,8'h22,4'd4},
    {2'd1,2'd1,8'h00,8'h33,4'd4},
    {2'd1,2'd1,8'h00,8'h0A,4'd4},
    {2'd1,2'd1,8'h00,8'h3B,4'd4},
    {2'd1,2'd1,8'h00,8'h3C,4'd5},  // R5 FC at 6-bit width
    {2'd0,2'd3,8'h10,8'h00,4'd0},  // open window
    {2'd1,2'd3,8'h00,8'h10,4'd2},  // R2
    {2'd0,2'd2,8'h09,8'h00,4'd0},
    {2'd1,2'd1,8'h00,8'h09,4'd6},  // R6 index readback
    {2'd1,2'd0,8'h00,8'h53,4'd9},  // R9
    {2'd0,2'd2,8'h0A,8'h00,4'd0},
    {2'd1,2'd0,8'h00,8'h3A,4'd9},
    {2'd0,2'd2,8'h0B,8'h00,4'd0},
    {2'd1,2'd0,8'h00,8'hB1,4'd9},
    {2'd0,2'd2,8'h0C,8'h00,4'd0},
    {2'd0,2'd0,8'h77,8'h00,4'd0},
    {2'd1,2'd0,8'h00,8'h41,4'd9},  // R9 write ignored
    {2'd0,2'd2,8'h08,8'h00,4'd0},
    {2'd0,2'd0,8'hFF,8'h00,4'd0},
    {2'd1,2'd0,8'h00,8'h01,4'd8},  // R8
    {2'd0,2'd2,8'h0D,8'h00,4'd0},
    {2'd0,2'd0,8'h12,8'h00,4'd0},
    {2'd0,2'd2,8'h0E,8'h00,4'd0},
    {2'd0,2'd0,8'h34,8'h00,4'd0},
    {2'd0,2'd2,8'h0F,8'h00,4'd0},
    {2'd0,2'd0,8'h56,8'h00,4'd0},
    {2'd1,2'd0,8'h00,8'h56,4'd10}, // R10
    {2'd0,2'd2,8'h10,8'h00,4'd0},
    {2'd0,2'd0,8'h03,8'h00,4'd0},
    {2'd1,2'd0,8'h00,8'h01,4'd11}, // R11
    {2'd0,2'd2,8'h20,8'h00,4'd0},
    {2'd0,2'd0,8'hAA,8'h00,4'd0},
    {2'd1,2'd0,8'h00,8'h00,4'd12}, // R12
    {2'd0,2'd1,8'h99,8'h00,4'd0},  // must be ignored
    {2'd0,2'd3,8'h00,8'h00,4'd0},  // close window
    {2'd0,2'd2,8'h06,8'h00,4'd0},
    {2'd1,2'd1,8'h00,8'h0A,4'd5},
    {2'd1,2'd1,8'h00,8'h3B,4'd5},
    {2'd1,2'd1,8'h00,8'hFC,4'd5},  // R5 full byte at 8-bit width
    {2'd1,2'd0,8'h00,8'h07,4'd7},  // R7 pointer untouched
    {2'd0,2'd1,8'h01,8'h00,4'd0},
    {2'd0,2'd1,8'h02,8'h00,4'd0},
    {2'd0,2'd1,8'h03,8'h00,4'd0},
    {2'd0,2'd2,8'h07,8'h00,4'd0},
    {2'd1,2'd1,8'h00,8'h01,4'd6},  // R6 counter was not shifted
    {2'd1,2'd1,8'h00,8'h02,4'd6},
    {2'd1,2'd1,8'h00,8'h03,4'd6},
    {2'd1,2'd0,8'h00,8'h08,4'd3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; re = 1'b0; port = p; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] p, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; re = 1'b1; port = p;
    #2 d = rdata;
    @(negedge clk);
    cs = 1'b0; re = 1'b0;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 cmd", cfg_cmd, 8'h00);
    check("R1 mask", cfg_mask, 24'hFFFFFF);
    check("R1 dac8", cfg_dac8, 1'b0);
    check("R1 pack", cfg_pack32, 1'b0);
    bus_rd(2'd0, got);
    check("R1 wptr", got, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][23:22] == 2'd0) bus_wr(VEC[i][21:20], VEC[i][19:12]);
      else begin
        bus_rd(VEC[i][21:20], got);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), got, VEC[i][11:4]);
      end
    end

    // bank state as seen on the configuration outputs
    check("R10 cfg_mask", cfg_mask, 24'h563412);
    check("R11 cfg_pack32", cfg_pack32, 1'b1);
    check("R8 cfg_dac8", cfg_dac8, 1'b1);
    bus_wr(2'd3, 8'h25);
    check("R2 cfg_cmd", cfg_cmd, 8'h25);
    bus_wr(2'd3, 8'h00);

    // R13 same-cycle commit and lookup of entry 9
    bus_wr(2'd0, 8'h09);
    bus_wr(2'd1, 8'h10); bus_wr(2'd1, 8'h20); bus_wr(2'd1, 8'h30);
    pix_index = 8'h09;
    bus_wr(2'd0, 8'h09);
    bus_wr(2'd1, 8'hA1); bus_wr(2'd1, 8'hB2);
    bus_wr(2'd1, 8'hC3);
    check("R13 old colour", pix_rgb, 24'h102030);
    @(negedge clk);
    check("R13 new colour", pix_rgb, 24'hA1B2C3);

    // R5 pixel path at 6-bit width
    bus_wr(2'd3, 8'h10);
    bus_wr(2'd2, 8'h08);
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd3, 8'h00);
    check("R5 cfg_dac8 off", cfg_dac8, 1'b0);
    check("R5 pix narrow", pix_rgb, 24'h213203);

    finish_run();
  end

endmodule